// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit gathers one-cycle event pulses from the receive path, the transmit path, the host bus logic and the line interface into a 32-bit status word. Each implemented bit latches when its pulse arrives. It stays set until software reads the status register, and that read clears every latched bit at once. A per-bit mask register and a one-bit global enable register form two levels of gating between the status word and the single interrupt line.

Bit 15 of the status word is not stored. It reads as the OR of the latched bits 16 to 25, the group that carries bus and reset-completion conditions. Software can therefore find out with one bit test that a rare condition is pending. Software can also raise bit 12 by writing to the status register, which lets it raise an interrupt on purpose.

Access is through a simple strobe port: a read strobe, a write strobe, a byte address, write data and combinational read data. Status sits at offset 0x10, mask at 0x14 and enable at 0x18.

Top module: `isr_unit`

## Requirements
- R1: After reset the status, mask and enable registers read 0 and `irq_o` is low.
- R2: A pulse on a live event bit sets that status bit from the next cycle. The live bits are 0 to 14, 16 and 20 to 25. The bit then holds until a read of the status register.
- R3: A read of offset 0x10 returns the latched word in the same cycle. From the next cycle all latched bits are cleared.
- R4: An event pulse that arrives in the same cycle as a clearing status read is still set after that read.
- R5: Status bit 15 reads as the OR of the latched bits 16 to 25. Pulses on bit 15, on bits 17 to 19 and on bits 26 to 31 have no effect, and those bits read 0.
- R6: The mask register at offset 0x14 stores all 32 written bits and reads them back.
- R7: The enable register at offset 0x18 stores only bit 0 of the write data. Bits 31 to 1 read 0.
- R8: `irq_o` is high exactly when the enable bit is 1 and the status word, with bit 15 included, ANDed with the mask is nonzero.
- R9: A write to offset 0x10 with data bit 12 set sets status bit 12. All other written bits are ignored, and a write with bit 12 clear changes nothing.
- R10: Reads of any other offset return 0, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | One-cycle event pulses, one per status bit |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request line |

## Verification
The bench uses the default parameters: a 32-bit word, an 8-bit address, offsets 0x10, 0x14 and 0x18, and the live-bit set 0x03F17FFF. With these values the dead bits 17 to 19 and 26 to 31 lie inside the random event stream, so a stray flop on any of them would show up. Sparse random pulses meet random clearing reads, which makes read-and-event collisions and summary-bit flips frequent. Directed cases cover the software-set bit and the two gating levels.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned ISR_W = 32;
  typedef logic [ISR_W-1:0] isr_word_t;
  // live event bits: 0..14, 16, 20..25 (bit 15 is derived)
  localparam isr_word_t ISR_LIVE_DEFAULT = 32'h03F1_7FFF;
endpackage

// File: rtl/isr_status_bank.sv
module isr_status_bank #(
  parameter int unsigned W       = 32,
  parameter logic [W-1:0] LIVE   = '0,
  parameter int unsigned SUM_BIT = 15,
  parameter int unsigned SUM_LO  = 16,
  parameter int unsigned SUM_HI  = 25,
  parameter int unsigned SWI_BIT = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  input  logic         swi_set_i,
  output logic [W-1:0] stat_q_o,
  output logic [W-1:0] word_o
);
  localparam logic [W-1:0] STORE = LIVE & ~(W'(1) << SUM_BIT);
  localparam logic [W-1:0] SWI_M = W'(1) << SWI_BIT;

  logic [W-1:0] set_vec;
  assign set_vec = (evt_i | (swi_set_i ? SWI_M : '0)) & STORE;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (STORE[i]) begin : g_flop
      logic q, d, ce;
      always_comb begin
        ce = clr_i | set_vec[i];
        d  = set_vec[i] | (q & ~clr_i);
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= 1'b0;
        else if (ce)  q <= d;
      end
      assign stat_q_o[i] = q;
    end else begin : g_none
      assign stat_q_o[i] = 1'b0;
    end
  end

  always_comb begin
    word_o          = stat_q_o;
    word_o[SUM_BIT] = |stat_q_o[SUM_HI:SUM_LO];
  end
endmodule

// File: rtl/isr_ctrl_regs.sv
module isr_ctrl_regs #(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK   = 8'h14,
  parameter logic [ADDR_W-1:0] OFS_ENABLE = 8'h18,
  parameter int unsigned SWI_BIT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      stat_word_i,
  output logic [W-1:0]      mask_q_o,
  output logic              en_q_o,
  output logic [W-1:0]      rdata_o,
  output logic              clr_o,
  output logic              swi_set_o
);
  logic hit_stat, hit_mask, hit_en;
  logic mask_ce, en_ce;
  logic [W-1:0] mask_d;
  logic en_d;

  always_comb begin
    hit_stat  = (addr_i == OFS_STATUS);
    hit_mask  = (addr_i == OFS_MASK);
    hit_en    = (addr_i == OFS_ENABLE);
    mask_ce   = wr_i & hit_mask;
    en_ce     = wr_i & hit_en;
    mask_d    = wdata_i;
    en_d      = wdata_i[0];
    clr_o     = rd_i & hit_stat;
    swi_set_o = wr_i & hit_stat & wdata_i[SWI_BIT];
    rdata_o   = '0;
    if (hit_stat)      rdata_o = stat_word_i;
    else if (hit_mask) rdata_o = mask_q_o;
    else if (hit_en)   rdata_o = {{(W-1){1'b0}}, en_q_o};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q_o <= '0;
    else if (mask_ce)  mask_q_o <= mask_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q_o <= 1'b0;
    else if (en_ce)  en_q_o <= en_d;
  end
endmodule

// File: rtl/isr_irq_gate.sv
module isr_irq_gate #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  output logic         irq_o
);
  always_comb irq_o = en_i & (|(word_i & mask_i));
endmodule

// File: rtl/isr_unit.sv
module isr_unit #(
  parameter int unsigned W       = isr_pkg::ISR_W,
  parameter int unsigned ADDR_W  = 8,
  parameter logic [W-1:0] LIVE   = isr_pkg::ISR_LIVE_DEFAULT,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK   = 8'h14,
  parameter logic [ADDR_W-1:0] OFS_ENABLE = 8'h18,
  parameter int unsigned SUM_BIT = 15,
  parameter int unsigned SUM_LO  = 16,
  parameter int unsigned SUM_HI  = 25,
  parameter int unsigned SWI_BIT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      evt_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [W-1:0]      reg_wdata_i,
  output logic [W-1:0]      reg_rdata_o,
  output logic              irq_o
);
  logic [W-1:0] stat_q, stat_word, mask_q;
  logic en_q, clr, swi_set;

  isr_status_bank #(
    .W(W), .LIVE(LIVE), .SUM_BIT(SUM_BIT), .SUM_LO(SUM_LO),
    .SUM_HI(SUM_HI), .SWI_BIT(SWI_BIT)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .clr_i(clr),
    .swi_set_i(swi_set), .stat_q_o(stat_q), .word_o(stat_word)
  );

  isr_ctrl_regs #(
    .W(W), .ADDR_W(ADDR_W), .OFS_STATUS(OFS_STATUS), .OFS_MASK(OFS_MASK),
    .OFS_ENABLE(OFS_ENABLE), .SWI_BIT(SWI_BIT)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(reg_rd_i), .wr_i(reg_wr_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .stat_word_i(stat_word),
    .mask_q_o(mask_q), .en_q_o(en_q), .rdata_o(reg_rdata_o),
    .clr_o(clr), .swi_set_o(swi_set)
  );

  isr_irq_gate #(.W(W)) u_gate (
    .word_i(stat_word), .mask_i(mask_q), .en_i(en_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/isr_unit_chk.sv
module isr_unit_chk #(
  parameter int unsigned W       = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter logic [W-1:0] LIVE   = '0,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK   = 8'h14,
  parameter logic [ADDR_W-1:0] OFS_ENABLE = 8'h18,
  parameter int unsigned SUM_BIT = 15,
  parameter int unsigned SUM_LO  = 16,
  parameter int unsigned SUM_HI  = 25,
  parameter int unsigned SWI_BIT = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [W-1:0]      evt_i,
  input logic              reg_rd_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [W-1:0]      reg_wdata_i,
  input logic [W-1:0]      reg_rdata_o,
  input logic              irq_o,
  input logic [W-1:0]      stat_q,
  input logic [W-1:0]      mask_q,
  input logic              en_q
);
  localparam logic [W-1:0] STORE = LIVE & ~(W'(1) << SUM_BIT);
  localparam logic [W-1:0] VISIBLE = STORE | (W'(1) << SUM_BIT);

  logic rd_st, wr_st, rd_en, wr_mk;
  assign rd_st = reg_rd_i & (reg_addr_i == OFS_STATUS);
  assign wr_st = reg_wr_i & (reg_addr_i == OFS_STATUS);
  assign rd_en = reg_rd_i & (reg_addr_i == OFS_ENABLE);
  assign wr_mk = reg_wr_i & (reg_addr_i == OFS_MASK);

  AST_HOLD_UNTIL_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_st |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R2
  AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_st && !wr_st) |=> (stat_q == ($past(evt_i) & STORE))); // R3
  AST_SUMMARY_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st |-> (reg_rdata_o[SUM_BIT] == ($countones(reg_rdata_o[SUM_HI:SUM_LO]) != 0))); // R5
  AST_DEAD_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st |-> ((reg_rdata_o & ~VISIBLE) == '0)); // R5
  AST_MASK_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mk |=> (mask_q == $past(reg_wdata_i))); // R6
  AST_ENABLE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |-> (reg_rdata_o[W-1:1] == '0)); // R7
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !irq_o); // R8
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((|(stat_q & mask_q)) || (mask_q[SUM_BIT] && (|stat_q[SUM_HI:SUM_LO])))); // R8
  AST_SOFT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st && reg_wdata_i[SWI_BIT]) |=> stat_q[SWI_BIT]); // R9
endmodule

bind isr_unit isr_unit_chk #(
  .W(W), .ADDR_W(ADDR_W), .LIVE(LIVE), .OFS_STATUS(OFS_STATUS),
  .OFS_MASK(OFS_MASK), .OFS_ENABLE(OFS_ENABLE), .SUM_BIT(SUM_BIT),
  .SUM_LO(SUM_LO), .SUM_HI(SUM_HI), .SWI_BIT(SWI_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .reg_rd_i(reg_rd_i),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .stat_q(stat_q),
  .mask_q(mask_q), .en_q(en_q)
);

// File: tb/tb_isr_unit.sv
module tb_isr_unit;
  localparam int CLK_P = 10;
  localparam logic [31:0] LIVE = 32'h03F1_7FFF;
  localparam logic [7:0] A_ST = 8'h10, A_MK = 8'h14, A_EN = 8'h18;

  logic clk = 1'b0, rst_n;
  logic [31:0] evt, wdata, rdata;
  logic rd, wr, irq;
  logic [7:0] addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_st, m_mk;
  logic m_en;

  always #(CLK_P/2) clk = ~clk;

  isr_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] f_word(logic [31:0] s);
    logic [31:0] w = s;
    w[15] = |s[25:16];
    return w;
  endfunction

  function automatic logic [31:0] f_read(logic [7:0] a);
    if (a == A_ST) return f_word(m_st);
    if (a == A_MK) return m_mk;
    if (a == A_EN) return {31'd0, m_en};
    return 32'd0;
  endfunction

  function automatic logic f_irq();
    return m_en & (|(f_word(m_st) & m_mk));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // advance model over the last edge, then drive and check the new cycle
  task automatic step(logic [31:0] e, logic r, logic w, logic [7:0] a, logic [31:0] d);
    @(posedge clk);
    if (rd && addr == A_ST) m_st = '0;
    m_st |= evt & LIVE & ~32'h8000;
    if (wr && addr == A_ST && wdata[12]) m_st[12] = 1'b1;
    if (wr && addr == A_MK) m_mk = wdata;
    if (wr && addr == A_EN) m_en = wdata[0];
    @(negedge clk);
    evt = e; rd = r; wr = w; addr = a; wdata = d;
    #1;
    chk("R8 irq", {31'd0, irq}, {31'd0, f_irq()});
    if (r) begin
      if (a == A_ST)      chk("R3 status read", rdata, f_read(a));
      else if (a == A_MK) chk("R6 mask read", rdata, f_read(a));
      else if (a == A_EN) chk("R7 enable read", rdata, f_read(a));
      else                chk("R10 other read", rdata, f_read(a));
    end
  endtask

  task automatic idle(); step('0, 0, 0, 8'h00, '0); endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_st = '0; m_mk = '0; m_en = 1'b0;
    rst_n = 1'b0; evt = '0; rd = 0; wr = 0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    step('0, 1, 0, A_ST, '0); chk("R1 status", rdata, 32'd0);
    step('0, 1, 0, A_MK, '0); chk("R1 mask", rdata, 32'd0);
    step('0, 1, 0, A_EN, '0); chk("R1 enable", rdata, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 latch and hold
    step(32'h0010_0001, 0, 0, A_MK, '0);
    idle(); idle();
    step('0, 1, 0, A_ST, '0); chk("R2 held bits", rdata, 32'h0010_8001);
    // R3 cleared
    step('0, 1, 0, A_ST, '0); chk("R3 cleared", rdata, 32'd0);
    // R4 coincident event survives
    step(32'h0000_0040, 1, 0, A_ST, '0); chk("R4 read before set", rdata, 32'd0);
    step('0, 1, 0, A_ST, '0); chk("R4 kept", rdata, 32'h0000_0040);
    // R5 dead bits and summary
    step(32'h840E_8000, 0, 0, A_ST, '0);
    step('0, 1, 0, A_ST, '0); chk("R5 dead bits", rdata, 32'd0);
    step(32'h0200_0000, 0, 0, A_ST, '0);
    step('0, 1, 0, A_ST, '0); chk("R5 summary", rdata, 32'h0200_8000);
    // R6 mask
    step('0, 0, 1, A_MK, 32'hA5A5_5A5A);
    step('0, 1, 0, A_MK, '0); chk("R6 mask", rdata, 32'hA5A5_5A5A);
    // R7 enable
    step('0, 0, 1, A_EN, 32'hFFFF_FFFE);
    step('0, 1, 0, A_EN, '0); chk("R7 bit0 clear", rdata, 32'd0);
    step('0, 0, 1, A_EN, 32'hFFFF_FFFF);
    step('0, 1, 0, A_EN, '0); chk("R7 bit0 only", rdata, 32'd1);
    // R8 gating
    step('0, 0, 1, A_MK, 32'h0000_0008);
    step(32'h0000_0008, 0, 0, A_MK, '0);
    idle(); chk("R8 irq on", {31'd0, irq}, 32'd1);
    step('0, 0, 1, A_EN, 32'd0);
    idle(); chk("R8 global off", {31'd0, irq}, 32'd0);
    step('0, 0, 1, A_EN, 32'd1);
    step('0, 1, 0, A_ST, '0);
    idle(); chk("R8 off after clear", {31'd0, irq}, 32'd0);
    step('0, 0, 1, A_MK, 32'h0000_8000);
    step(32'h0010_0000, 0, 0, A_ST, '0);
    idle(); chk("R8 via summary", {31'd0, irq}, 32'd1);
    step('0, 1, 0, A_ST, '0);
    // R9 software set
    step('0, 0, 1, A_ST, 32'hFFFF_EFFF);
    step('0, 1, 0, A_ST, '0); chk("R9 ignored bits", rdata, 32'd0);
    step('0, 0, 1, A_ST, 32'h0000_1000);
    step('0, 1, 0, A_ST, '0); chk("R9 soft set", rdata, 32'h0000_1000);
    // R10 other offset
    step('0, 0, 1, 8'h1C, 32'h1234_5678);
    step('0, 1, 0, 8'h1C, '0); chk("R10 read zero", rdata, 32'd0);
    step('0, 1, 0, A_MK, '0); chk("R10 mask kept", rdata, 32'h0000_8000);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] e, d;
      logic [7:0] a;
      int k;
      e = $urandom & $urandom & $urandom & $urandom;
      d = $urandom;
      k = $urandom_range(0, 9);
      a = (k < 5) ? A_ST : (k < 7) ? A_MK : (k < 9) ? A_EN : 8'($urandom);
      step(e, ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0), a, d);
    end
    idle();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule